// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider with Phase/Frequency Detector

This block is the synchronous digital core of a tuning frequency synthesizer. The local oscillator first passes through an external dual-modulus prescaler. Each prescaler output edge then reaches this block as a one-cycle tick on the low-band or the high-band input. The block divides the selected tick stream with a programmable counter. In pulse-swallow operation it also uses a swallow counter and drives the modulus control line back to the prescaler. A second tick stream comes from a 75 kHz crystal domain. A selectable power-of-two divider turns it into the comparison reference.

A phase/frequency detector compares the divided pulse with the reference pulse and drives a tri-state error output. One port enables the pad driver and a second port gives the pump direction. The detector also keeps a sticky unlock flag that clears when it is read. Software programs the block through a small write port. The operating mode and the reference select take effect at once. The divide word is staged and is moved into the counters only by a separate transfer write. The synthesizer stays idle while the chip-enable input is low or while either setting selects the off state.

Top module: `pll_synth_core`

## Requirements
- R1: After reset the mode is off (code 0), the reference select is 0 and both divide words are 0. err_oe, err_up, mod_ctl, unlock, lo_en and hi_en are all low.
- R2: The block runs only while ce is high, the mode code is 1, 2 or 3, and the reference select is between 1 and REF_CODES. Otherwise err_oe, err_up, mod_ctl, lo_en and hi_en are low, the detector is cleared and the counters are held at their reload values.
- R3: Modes 1 (direct) and 2 (swallow, low band) count lo_tick and raise lo_en. Mode 3 (swallow, high band) counts hi_tick and raises hi_en. Ticks on the input that is not selected have no effect.
- R4: Register writes use reg_addr. Address 0 holds the mode in wdata[3:0] and address 1 holds the reference select in wdata[3:0]. Address 2 holds the staged divide word: the swallow count in bits [SW_W-1:0] and the program count in the bits above. A write to address 3 copies the staged word to the active word, and the counters restart from it on the next cycle. A staged write by itself does not change the division.
- R5: In direct mode one divided pulse occurs every P selected ticks, where P is the program count. A P of 0 or 1 gives one pulse per tick. mod_ctl stays low.
- R6: In swallow modes mod_ctl is high while the swallow counter is non-zero. Each selected tick decrements the program counter and, while it is non-zero, the swallow counter. When the program counter expires, a divided pulse is produced, both counters reload and mod_ctl rises again.
- R7: A reference select k in 1..REF_CODES gives one reference pulse every 2^(k-1) ref_tick pulses.
- R8: A reference pulse seen while the detector is idle raises err_oe with err_up high (pump up). A divided pulse seen while idle raises err_oe with err_up low (pump down). The opposite pulse returns the detector to idle, where err_oe is low (high impedance). Coincident pulses leave it idle.
- R9: unlock is set when the detector leaves idle for one direction. It clears on the cycle after an unlock_rd strobe unless a new set occurs in that same cycle; a set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Chip enable (synchronous to clk); low disables the synthesizer |
| lo_tick | input | 1 | One-cycle pulse per low-band prescaler edge |
| hi_tick | input | 1 | One-cycle pulse per high-band prescaler edge |
| ref_tick | input | 1 | One-cycle pulse per 75 kHz crystal edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 reference select, 2 stage, 3 transfer) |
| reg_wdata | input | DATA_W | Register write data |
| unlock_rd | input | 1 | Read strobe for the unlock flag; clears it |
| mod_ctl | output | 1 | Modulus control to the prescaler, high selects divide-by-(P+1) |
| err_oe | output | 1 | Drive enable of the tri-state error pad |
| err_up | output | 1 | Error pad level, 1 pump up, 0 pump down |
| unlock | output | 1 | Sticky unlock flag |
| lo_en | output | 1 | Low-band input amplifier enable |
| hi_en | output | 1 | High-band input amplifier enable |

## Verification
Register writes and ce changes show on lo_en, hi_en and mod_ctl one cycle after the write or change. A write to address 3 shows on mod_ctl two cycles later, because the active word is loaded first and the counters reload on the next cycle. A tick that changes a counter moves mod_ctl one cycle later. A tick that completes a divided or reference pulse moves err_oe, err_up and unlock two cycles later: one register forms the pulse and one more holds the detector state. The driver queues each expected value with that latency, counted from the cycle it drives the stimulus. The monitor compares each queued value in exactly that cycle and treats any entry that goes past its cycle as a failure.

// File: rtl/pll_pkg.sv
package pll_pkg;

  // mode register codes (4 bits written at address 0)
  localparam logic [3:0] MODE_OFF    = 4'd0;
  localparam logic [3:0] MODE_DIRECT = 4'd1;
  localparam logic [3:0] MODE_SW_LO  = 4'd2;
  localparam logic [3:0] MODE_SW_HI  = 4'd3;

  // register addresses
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_REFSEL = 2'd1;
  localparam logic [1:0] ADDR_STAGE  = 2'd2;
  localparam logic [1:0] ADDR_XFER   = 2'd3;

  typedef enum logic [1:0] {
    DIV_OFF,
    DIV_DIRECT,
    DIV_SWALLOW
  } div_kind_e;

  function automatic div_kind_e decode_mode(input logic [3:0] code);
    case (code)
      MODE_DIRECT:            return DIV_DIRECT;
      MODE_SW_LO, MODE_SW_HI: return DIV_SWALLOW;
      default:                return DIV_OFF;
    endcase
  endfunction

endpackage

// File: rtl/pll_regs.sv
module pll_regs #(
  parameter int DATA_W = 16,
  parameter int SW_W   = 5,
  localparam int PC_W  = DATA_W - SW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [3:0]        mode_q,
  output logic [3:0]        refsel_q,
  output logic [SW_W-1:0]   sw_val,
  output logic [PC_W-1:0]   pc_val,
  output logic              reload
);
  import pll_pkg::*;

  logic [DATA_W-1:0] stage_q, stage_n;
  logic [DATA_W-1:0] act_q, act_n;
  logic [3:0]        mode_n, refsel_n;
  logic              reload_n;
  logic              wr_mode, wr_ref, wr_stage, wr_xfer;

  always_comb begin
    wr_mode  = reg_wr && (reg_addr == ADDR_MODE);
    wr_ref   = reg_wr && (reg_addr == ADDR_REFSEL);
    wr_stage = reg_wr && (reg_addr == ADDR_STAGE);
    wr_xfer  = reg_wr && (reg_addr == ADDR_XFER);
  end

  always_comb begin
    mode_n   = mode_q;
    refsel_n = refsel_q;
    stage_n  = stage_q;
    act_n    = act_q;
    reload_n = wr_xfer;
    if (wr_mode)  mode_n   = reg_wdata[3:0];
    if (wr_ref)   refsel_n = reg_wdata[3:0];
    if (wr_stage) stage_n  = reg_wdata;
    if (wr_xfer)  act_n    = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      refsel_q <= 4'd0;
      stage_q  <= '0;
      act_q    <= '0;
      reload   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      refsel_q <= refsel_n;
      stage_q  <= stage_n;
      act_q    <= act_n;
      reload   <= reload_n;
    end
  end

  assign sw_val = act_q[SW_W-1:0];
  assign pc_val = act_q[DATA_W-1:SW_W];

  // R4
  xfer_copies_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_xfer |=> (act_q == $past(stage_q)) && reload);

  // R4
  stage_alone_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stage && !wr_xfer) |=> $stable(act_q));

endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int REF_CODES = 8,
  localparam int RC_W     = (REF_CODES > 1) ? REF_CODES - 1 : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ref_tick,
  input  logic [3:0] refsel,
  output logic       ref_pulse
);

  logic [RC_W-1:0] cnt_q, cnt_n;
  logic [RC_W-1:0] limit;
  logic            pulse_n;

  // divide ratio 2^(refsel-1): terminal count is ratio-1
  always_comb begin
    limit = RC_W'((32'd1 << (refsel - 4'd1)) - 32'd1);
  end

  always_comb begin
    cnt_n   = cnt_q;
    pulse_n = 1'b0;
    if (!en) begin
      cnt_n = '0;
    end else if (ref_tick) begin
      if (cnt_q >= limit) begin
        cnt_n   = '0;
        pulse_n = 1'b1;
      end else begin
        cnt_n = cnt_q + RC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ref_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      ref_pulse <= pulse_n;
    end
  end

  // R7
  ref_pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick) && $past(en));

  // R7
  ref_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_tick && cnt_q < limit) |=> (cnt_q == $past(cnt_q) + RC_W'(1)) && !ref_pulse);

endmodule

// File: rtl/pll_fdiv.sv
module pll_fdiv #(
  parameter int SW_W = 5,
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            swallow,
  input  logic            tick,
  input  logic            reload,
  input  logic [SW_W-1:0] sw_val,
  input  logic [PC_W-1:0] pc_val,
  output logic            mod_ctl,
  output logic            div_pulse
);

  logic [SW_W-1:0] sw_q, sw_n;
  logic [PC_W-1:0] pc_q, pc_n;
  logic            pulse_n;
  logic            expire;

  assign expire = (pc_q <= PC_W'(1));

  always_comb begin
    sw_n    = sw_q;
    pc_n    = pc_q;
    pulse_n = 1'b0;
    if (!en || reload) begin
      sw_n = sw_val;
      pc_n = pc_val;
    end else if (tick) begin
      if (expire) begin
        sw_n    = sw_val;
        pc_n    = pc_val;
        pulse_n = 1'b1;
      end else begin
        pc_n = pc_q - PC_W'(1);
        if (swallow && (sw_q != '0)) sw_n = sw_q - SW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q      <= '0;
      pc_q      <= '0;
      div_pulse <= 1'b0;
    end else begin
      sw_q      <= sw_n;
      pc_q      <= pc_n;
      div_pulse <= pulse_n;
    end
  end

  assign mod_ctl = en && swallow && (sw_q != '0);

  // R5
  prog_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !reload && tick && !expire) |=> (pc_q == $past(pc_q) - PC_W'(1)) && !div_pulse);

  // R5
  prog_expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !reload && tick && expire) |=> div_pulse && (pc_q == $past(pc_val)));

  // R6
  swallow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && swallow && !reload && tick && !expire && sw_q != '0)
      |=> sw_q == $past(sw_q) - SW_W'(1));

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_p,
  input  logic div_p,
  input  logic unlock_rd,
  output logic up_q,
  output logic dn_q,
  output logic unlock_q
);

  logic up_t, dn_t, up_n, dn_n;
  logic set_unlock, unlock_n;

  always_comb begin
    up_t = up_q | ref_p;
    dn_t = dn_q | div_p;
    if (!en || (up_t && dn_t)) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end else begin
      up_n = up_t;
      dn_n = dn_t;
    end
    set_unlock = en && !up_q && !dn_q && (ref_p ^ div_p);
    if (set_unlock)     unlock_n = 1'b1;
    else if (unlock_rd) unlock_n = 1'b0;
    else                unlock_n = unlock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      up_q     <= up_n;
      dn_q     <= dn_n;
      unlock_q <= unlock_n;
    end
  end

  // R2
  off_clears_detector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !up_q && !dn_q);

  // R8
  ref_first_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_p && !div_p && !up_q && !dn_q) |=> up_q && !dn_q);

  // R8
  div_first_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_p && !ref_p && !up_q && !dn_q) |=> dn_q && !up_q);

  // R9
  unlock_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up_q && !dn_q && (ref_p ^ div_p)) |=> unlock_q);

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
  parameter int DATA_W    = 16,
  parameter int SW_W      = 5,
  parameter int REF_CODES = 8,
  localparam int PC_W     = DATA_W - SW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              lo_tick,
  input  logic              hi_tick,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              unlock_rd,
  output logic              mod_ctl,
  output logic              err_oe,
  output logic              err_up,
  output logic              unlock,
  output logic              lo_en,
  output logic              hi_en
);
  import pll_pkg::*;

  logic [3:0]      mode_q, refsel_q;
  logic [SW_W-1:0] sw_val;
  logic [PC_W-1:0] pc_val;
  logic            reload;
  div_kind_e       kind;
  logic            ref_ok, en, use_hi, swallow, tick_sel;
  logic            ref_pulse, div_pulse;
  logic            up_q, dn_q;

  pll_regs #(.DATA_W(DATA_W), .SW_W(SW_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .mode_q   (mode_q),
    .refsel_q (refsel_q),
    .sw_val   (sw_val),
    .pc_val   (pc_val),
    .reload   (reload)
  );

  always_comb begin
    kind     = decode_mode(mode_q);
    ref_ok   = (refsel_q != 4'd0) && (int'(refsel_q) <= REF_CODES);
    en       = ce && (kind != DIV_OFF) && ref_ok;
    use_hi   = (mode_q == MODE_SW_HI);
    swallow  = (kind == DIV_SWALLOW);
    tick_sel = use_hi ? hi_tick : lo_tick;
  end

  pll_ref_div #(.REF_CODES(REF_CODES)) i_ref_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_tick (ref_tick),
    .refsel   (refsel_q),
    .ref_pulse(ref_pulse)
  );

  pll_fdiv #(.SW_W(SW_W), .PC_W(PC_W)) i_fdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .swallow  (swallow),
    .tick     (tick_sel),
    .reload   (reload),
    .sw_val   (sw_val),
    .pc_val   (pc_val),
    .mod_ctl  (mod_ctl),
    .div_pulse(div_pulse)
  );

  pll_pfd i_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_p    (ref_pulse),
    .div_p    (div_pulse),
    .unlock_rd(unlock_rd),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .unlock_q (unlock)
  );

  assign err_oe = en && (up_q || dn_q);
  assign err_up = en && up_q;
  assign lo_en  = en && !use_hi;
  assign hi_en  = en && use_hi;

  // R6
  mod_low_in_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DIRECT) |-> !mod_ctl);

  // R3
  one_band_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_en && hi_en));

endmodule

// File: tb/test_pll_synth_core.sv
module test_pll_synth_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, lo_tick, hi_tick, ref_tick, reg_wr, unlock_rd;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        mod_ctl, err_oe, err_up, unlock, lo_en, hi_en;

  always #10 clk = ~clk;

  pll_synth_core i_pll_synth_core (
    .clk(clk), .rst_n(rst_n), .ce(ce), .lo_tick(lo_tick), .hi_tick(hi_tick),
    .ref_tick(ref_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .unlock_rd(unlock_rd), .mod_ctl(mod_ctl),
    .err_oe(err_oe), .err_up(err_up), .unlock(unlock), .lo_en(lo_en),
    .hi_en(hi_en)
  );

  localparam int K_OE = 0, K_UP = 1, K_MOD = 2, K_UNL = 3, K_LO = 4, K_HI = 5;

  typedef struct {
    int    due;
    int    kind;
    bit    val;
    string req;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  function automatic logic actual(int kind);
    case (kind)
      K_OE:    return err_oe;
      K_UP:    return err_up;
      K_MOD:   return mod_ctl;
      K_UNL:   return unlock;
      K_LO:    return lo_en;
      default: return hi_en;
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      K_OE:    return "err_oe";
      K_UP:    return "err_up";
      K_MOD:   return "mod_ctl";
      K_UNL:   return "unlock";
      K_LO:    return "lo_en";
      default: return "hi_en";
    endcase
  endfunction

  // monitor: pops due items mid-high phase
  always @(posedge clk) begin
    cyc = cyc + 1;
    #5;
    for (int i = 0; i < sb.size(); ) begin
      if (sb[i].due == cyc) begin
        n_chk++;
        if (actual(sb[i].kind) !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s %s at cycle %0d: actual %b expected %b", sb[i].req,
                   kname(sb[i].kind), cyc, actual(sb[i].kind), sb[i].val);
        end
        sb.delete(i);
      end else if (sb[i].due < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s %s missed cycle %0d: actual none expected %b", sb[i].req,
                 kname(sb[i].kind), sb[i].due, sb[i].val);
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic expect_v(int lat, int kind, bit val, string req);
    item_t it;
    it.due  = cyc + lat;
    it.kind = kind;
    it.val  = val;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic drive(bit r, bit l, bit h, bit wr, logic [1:0] a, logic [15:0] d, bit rd);
    @(negedge clk);
    ref_tick  = r;
    lo_tick   = l;
    hi_tick   = h;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    unlock_rd = rd;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 2'd0, 16'd0, 0);
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    drive(0, 0, 0, 1, a, d, 0);
  endtask

  task automatic ref1();  drive(1, 0, 0, 0, 2'd0, 16'd0, 0); endtask
  task automatic lo1();   drive(0, 1, 0, 0, 2'd0, 16'd0, 0); endtask
  task automatic hi1();   drive(0, 0, 1, 0, 2'd0, 16'd0, 0); endtask
  task automatic rd1();   drive(0, 0, 0, 0, 2'd0, 16'd0, 1); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; lo_tick = 0; hi_tick = 0; ref_tick = 0;
    reg_wr = 0; reg_addr = 2'd0; reg_wdata = 16'd0; unlock_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    nop(1);
    expect_v(1, K_OE, 0, "R1"); expect_v(1, K_UP, 0, "R1");
    expect_v(1, K_MOD, 0, "R1"); expect_v(1, K_UNL, 0, "R1");
    expect_v(1, K_LO, 0, "R1"); expect_v(1, K_HI, 0, "R1");
    nop(1);
    ce = 1'b1;
    // R2: mode still off
    wreg(2'd1, 16'd1);
    expect_v(1, K_LO, 0, "R2");
    // R3: direct mode uses low band
    wreg(2'd0, 16'd1);
    expect_v(1, K_LO, 1, "R3"); expect_v(1, K_HI, 0, "R3");
    // R4: staged program count 3, no transfer -> active P=0
    wreg(2'd2, 16'd96);
    nop(2);
    ref1();
    expect_v(2, K_OE, 1, "R8"); expect_v(2, K_UP, 1, "R8"); expect_v(2, K_UNL, 1, "R9");
    lo1();
    expect_v(2, K_OE, 0, "R4");
    nop(3);
    rd1();
    expect_v(1, K_UNL, 0, "R9");
    // R4: transfer makes P=3
    wreg(2'd3, 16'd0);
    nop(3);
    ref1();
    expect_v(2, K_OE, 1, "R5"); expect_v(2, K_UNL, 1, "R9");
    lo1();
    expect_v(1, K_MOD, 0, "R5");
    lo1();
    expect_v(2, K_OE, 1, "R5");
    lo1();
    expect_v(2, K_OE, 0, "R5");
    nop(3);
    // R8: divided pulse first -> pump down
    lo1(); lo1(); lo1();
    expect_v(2, K_OE, 1, "R8"); expect_v(2, K_UP, 0, "R8");
    nop(2);
    ref1();
    expect_v(2, K_OE, 0, "R8");
    nop(3);
    // R3: high-band ticks ignored in direct mode
    hi1(); hi1(); hi1();
    nop(2);
    ref1();
    expect_v(2, K_OE, 1, "R3"); expect_v(2, K_UP, 1, "R3");
    lo1(); lo1(); lo1();
    expect_v(2, K_OE, 0, "R5");
    nop(3);
    // R7: reference divide by 2
    wreg(2'd1, 16'd2);
    ref1();
    expect_v(2, K_OE, 0, "R7");
    nop(2);
    ref1();
    expect_v(2, K_OE, 1, "R7"); expect_v(2, K_UP, 1, "R7");
    lo1(); lo1(); lo1();
    expect_v(2, K_OE, 0, "R8");
    nop(3);
    // R6: swallow low band, A=2 P=4
    wreg(2'd0, 16'd2);
    expect_v(1, K_LO, 1, "R3");
    wreg(2'd2, 16'd130);
    wreg(2'd3, 16'd0);
    expect_v(2, K_MOD, 1, "R6");
    nop(3);
    lo1(); expect_v(1, K_MOD, 1, "R6");
    lo1(); expect_v(1, K_MOD, 0, "R6");
    lo1(); expect_v(1, K_MOD, 0, "R6");
    lo1(); expect_v(1, K_MOD, 1, "R6");
    expect_v(2, K_OE, 1, "R6"); expect_v(2, K_UP, 0, "R6");
    nop(2);
    ref1(); ref1();
    expect_v(2, K_OE, 0, "R8");
    nop(3);
    // R3: swallow high band
    wreg(2'd0, 16'd3);
    expect_v(1, K_HI, 1, "R3"); expect_v(1, K_LO, 0, "R3");
    lo1(); lo1();
    expect_v(1, K_MOD, 1, "R3");
    hi1(); hi1();
    expect_v(1, K_MOD, 0, "R6");
    nop(2);
    // R2: chip enable low
    ref1(); ref1();
    expect_v(2, K_OE, 1, "R8"); expect_v(2, K_UP, 1, "R8");
    nop(3);
    @(negedge clk); ce = 1'b0;
    expect_v(1, K_OE, 0, "R2"); expect_v(1, K_HI, 0, "R2"); expect_v(1, K_UP, 0, "R2");
    hi1(); hi1();
    nop(2);
    @(negedge clk); ce = 1'b1;
    expect_v(1, K_MOD, 1, "R2"); expect_v(1, K_OE, 0, "R2");
    nop(2);
    // R2: reference select 0 and out-of-range code disable
    wreg(2'd1, 16'd0);
    expect_v(1, K_HI, 0, "R2"); expect_v(1, K_MOD, 0, "R2");
    wreg(2'd1, 16'd9);
    expect_v(1, K_HI, 0, "R2");
    wreg(2'd1, 16'd1);
    expect_v(1, K_HI, 1, "R2");
    nop(2);
    // R9: read clear, then set wins over a coincident read
    rd1();
    expect_v(1, K_UNL, 0, "R9");
    nop(1);
    ref1();
    rd1();
    expect_v(1, K_UNL, 1, "R9");
    nop(6);
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end

endmodule